// File: doc/BRIEF.md
# Digital frequency-lock error modulator

This block is the digital heart of a frequency-locked loop used to test an oscillator. A free-running counter in the oscillator clock domain is sampled at the end of every measurement window. The window is a programmable number of reference clock cycles. The block subtracts the cycles counted in one window from a programmable expected count and adds a signed programmable offset. The oscillator therefore settles at a frequency offset chosen digitally, without touching the reference or sweeping the tuning voltage.

The signed error drives a first-order sigma-delta modulator, which runs once per reference cycle. Its carry stream appears as one-cycle `pump_up` or `pump_dn` pulses, which switch an external charge pump into an integrating capacitor. The capacitor voltage steers the oscillator. A lock flag reports when the error has stayed inside a tolerance for enough windows in a row.

The oscillator-domain count is snapshotted on request from the reference domain. It is carried across as a Gray code through two flops and converted back to binary. It is consumed one full window later, so the snapshot is long settled when it is read. Because of this, each published error describes the window that ended at the previous boundary.

Top module: `flock_err_mod`

## Requirements
- R1: While reset is asserted, `pump_up`, `pump_dn`, `err_valid` and `locked` are low and `err_out` is zero.
- R2: At each window boundary (every `win_len` reference cycles, `win_len` at least 16), `err_valid` pulses for one cycle and `err_out` becomes `target + offset - M`. Here M is the count of oscillator cycles in one earlier window, taken modulo 2^17, and the result is a signed 18-bit value. The first two boundaries after reset publish nothing, so the first pulse comes 3*`win_len` reference cycles after reset is released.
- R3: `err_out` and `locked` change only in a cycle in which `err_valid` is high.
- R4: `offset` is sampled only at a window boundary. A change in the middle of a window leaves `err_out` untouched until the next `err_valid`, and that next value uses the new offset.
- R5: Every reference cycle, the modulator adds min(|`err_out`|, 2^ACC_W-1) to an ACC_W-bit accumulator (ACC_W = 8 by default). A carry out gives a one-cycle pump pulse. Over any 256 consecutive cycles of constant error, the pulse count equals that clipped magnitude.
- R6: A positive error gives pulses only on `pump_up`, and a negative error gives pulses only on `pump_dn`. The two are never high in the same cycle.
- R7: A zero error produces no pump pulses.
- R8: With `enable` low, the accumulator is cleared and both pump outputs are low from the next cycle. Measurement and error publication continue.
- R9: At each `err_valid`, `locked` is set once |error| <= `tol` has held for `lock_len` consecutive published windows (equality counts as inside). It is cleared at the first published error with |error| > `tol`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; window timing, error and modulator |
| osc_clk | input | 1 | Oscillator clock under test |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| enable | input | 1 | Modulator enable; low clears accumulator and pumps |
| win_len | input | 16 | Window length in reference cycles |
| target | input | 17 | Expected oscillator count per window |
| offset | input | 18 | Signed offset added to the error |
| tol | input | 17 | Lock tolerance on error magnitude |
| lock_len | input | 4 | Consecutive in-tolerance windows needed for lock |
| pump_up | output | 1 | One-cycle pump-up pulse |
| pump_dn | output | 1 | One-cycle pump-down pulse |
| err_out | output | 18 | Signed error of the last window |
| err_valid | output | 1 | One-cycle strobe at each published error |
| locked | output | 1 | Lock flag |

## Verification
A new error can be published in the same cycle in which the accumulator carries. The lock flag is updated in that same cycle. The bench provokes this by moving the offset across zero, and across the tolerance edge, at window boundaries while pulses are running. Each new error and lock state is judged against a scoreboard entry. Pulses are then counted over 256 cycles after each boundary: the count must equal the clipped magnitude, with no pulse in the wrong direction and no cycle where both pumps are high.

// File: rtl/flock_err_mod.sv
module flock_err_mod #(
  parameter int CNT_W = 17,
  parameter int ACC_W = 8,
  parameter int WIN_W = 16,
  parameter int LCK_W = 4
) (
  input  logic                    ref_clk,
  input  logic                    osc_clk,
  input  logic                    rst_n,
  input  logic                    enable,
  input  logic [WIN_W-1:0]        win_len,
  input  logic [CNT_W-1:0]        target,
  input  logic signed [CNT_W:0]   offset,
  input  logic [CNT_W-1:0]        tol,
  input  logic [LCK_W-1:0]        lock_len,
  output logic                    pump_up,
  output logic                    pump_dn,
  output logic signed [CNT_W:0]   err_out,
  output logic                    err_valid,
  output logic                    locked
);
  localparam int ERR_W = CNT_W + 1;
  localparam logic [ERR_W-1:0] MAXM = ERR_W'((1 << ACC_W) - 1);

  // window timing (reference domain)
  logic [WIN_W-1:0] wcnt;
  logic             req_t;
  wire              wend = (wcnt == win_len - 1'b1);

  always_ff @(posedge ref_clk or negedge rst_n)
    if (!rst_n) begin
      wcnt  <= '0;
      req_t <= 1'b0;
    end else begin
      wcnt  <= wend ? '0 : wcnt + 1'b1;
      if (wend) req_t <= ~req_t;
    end

  // oscillator domain: free-running count, Gray snapshot on request
  logic [2:0]       req_s;
  logic [CNT_W-1:0] ocnt, gsnap;
  wire              snap = req_s[2] ^ req_s[1];

  always_ff @(posedge osc_clk or negedge rst_n)
    if (!rst_n) begin
      req_s <= '0;
      ocnt  <= '0;
      gsnap <= '0;
    end else begin
      req_s <= {req_s[1:0], req_t};
      ocnt  <= ocnt + 1'b1;
      if (snap) gsnap <= ocnt ^ (ocnt >> 1);
    end

  // back into the reference domain
  logic [CNT_W-1:0] g1, g2, bsnap, prev;
  logic [1:0]       seen;

  always_ff @(posedge ref_clk or negedge rst_n)
    if (!rst_n) begin
      g1 <= '0;
      g2 <= '0;
    end else begin
      g1 <= gsnap;
      g2 <= g1;
    end

  always_comb
    for (int i = 0; i < CNT_W; i++) bsnap[i] = ^(g2 >> i);

  wire [CNT_W-1:0]        meas = bsnap - prev;
  wire signed [ERR_W-1:0] errn = $signed({1'b0, target}) + offset - $signed({1'b0, meas});
  wire [ERR_W-1:0]        nmag = errn[ERR_W-1] ? ERR_W'(-errn) : ERR_W'(errn);
  wire                    in_tol = (nmag <= {1'b0, tol});

  logic [LCK_W-1:0] run;
  wire  [LCK_W-1:0] run_nx = !in_tol ? '0 : (run < lock_len ? run + 1'b1 : run);

  always_ff @(posedge ref_clk or negedge rst_n)
    if (!rst_n) begin
      prev      <= '0;
      seen      <= '0;
      err_out   <= '0;
      err_valid <= 1'b0;
      run       <= '0;
      locked    <= 1'b0;
    end else begin
      err_valid <= 1'b0;
      if (wend) begin
        prev <= bsnap;
        if (seen != 2'd2) seen <= seen + 1'b1;
        else begin
          err_out   <= errn;
          err_valid <= 1'b1;
          run       <= run_nx;
          locked    <= in_tol && (run_nx >= lock_len);
        end
      end
    end

  // first-order sigma-delta on the clipped magnitude
  logic [ACC_W-1:0] acc;
  wire  [ERR_W-1:0] emag = err_out[ERR_W-1] ? ERR_W'(-err_out) : ERR_W'(err_out);
  wire  [ACC_W-1:0] step = (emag > MAXM) ? MAXM[ACC_W-1:0] : emag[ACC_W-1:0];
  wire  [ACC_W:0]   sum  = {1'b0, acc} + {1'b0, step};

  always_ff @(posedge ref_clk or negedge rst_n)
    if (!rst_n) begin
      acc     <= '0;
      pump_up <= 1'b0;
      pump_dn <= 1'b0;
    end else if (!enable) begin
      acc     <= '0;
      pump_up <= 1'b0;
      pump_dn <= 1'b0;
    end else begin
      acc     <= sum[ACC_W-1:0];
      pump_up <= sum[ACC_W] & ~err_out[ERR_W-1];
      pump_dn <= sum[ACC_W] &  err_out[ERR_W-1];
    end
endmodule

module flock_err_mod_chk #(
  parameter int ERR_W = 18
) (
  input logic             ref_clk,
  input logic             rst_n,
  input logic             enable,
  input logic             pump_up,
  input logic             pump_dn,
  input logic [ERR_W-1:0] err_out,
  input logic             err_valid,
  input logic             locked
);
  assert_pumps_exclusive_R6: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !(pump_up && pump_dn));

  assert_up_needs_positive_R6: assert property (@(posedge ref_clk) disable iff (!rst_n)
    pump_up |-> ($past(err_out) != '0 && !$past(err_out[ERR_W-1])));

  assert_dn_needs_negative_R6: assert property (@(posedge ref_clk) disable iff (!rst_n)
    pump_dn |-> $past(err_out[ERR_W-1]));

  assert_zero_quiet_R7: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (err_out == '0) |=> (!pump_up && !pump_dn));

  assert_disable_quiet_R8: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !enable |=> (!pump_up && !pump_dn));

  assert_err_held_R3: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !err_valid |-> ($stable(err_out) && $stable(locked)));

  assert_valid_single_R2: assert property (@(posedge ref_clk) disable iff (!rst_n)
    err_valid |=> !err_valid);
endmodule

bind flock_err_mod flock_err_mod_chk #(.ERR_W(CNT_W + 1)) chk_i (
  .ref_clk(ref_clk), .rst_n(rst_n), .enable(enable),
  .pump_up(pump_up), .pump_dn(pump_dn), .err_out(err_out),
  .err_valid(err_valid), .locked(locked));

// File: tb/flock_err_mod_tb_top.sv
`timescale 1ns/1ps
module flock_err_mod_tb_top;
  localparam int REF_PERIOD = 40;
  localparam int WIN = 300;

  logic ref_clk = 1'b0, osc_clk = 1'b0, rst_n = 1'b0, enable = 1'b1;
  logic [15:0] win_len = 16'(WIN);
  logic [16:0] target = 17'd2400;
  logic signed [17:0] offset = '0;
  logic [16:0] tol = 17'd5;
  logic [3:0] lock_len = 4'd3;
  logic pump_up, pump_dn, err_valid, locked;
  logic signed [17:0] err_out;

  real osc_half = 2.5;
  int n_chk = 0, n_fail = 0, overlap = 0, unstable = 0;
  bit done = 0;
  logic [19:0] exp_q[$];

  flock_err_mod dut_i (
    .ref_clk(ref_clk), .osc_clk(osc_clk), .rst_n(rst_n), .enable(enable),
    .win_len(win_len), .target(target), .offset(offset), .tol(tol),
    .lock_len(lock_len), .pump_up(pump_up), .pump_dn(pump_dn),
    .err_out(err_out), .err_valid(err_valid), .locked(locked));

  initial forever #(REF_PERIOD/2) ref_clk = ~ref_clk;
  initial begin #1.3; forever #(osc_half) osc_clk = ~osc_clk; end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: pops one scoreboard entry per published error
  logic signed [17:0] last_err;
  logic last_lock;
  bit seen_valid = 0;
  always @(negedge ref_clk) if (rst_n) begin
    if (pump_up && pump_dn) overlap++;
    if (err_valid) begin
      if (exp_q.size() == 0) check("R2 unexpected err_valid", 1, 0);
      else begin
        logic [19:0] it;
        it = exp_q.pop_front();
        if (!it[19]) begin
          check("R2 err_out", int'(err_out), int'($signed(it[17:0])));
          check("R9 locked", int'(locked), int'(it[18]));
        end
      end
      last_err = err_out; last_lock = locked; seen_valid = 1;
    end else if (seen_valid && (err_out !== last_err || locked !== last_lock)) unstable++;
  end

  task automatic push(input bit dc, input bit lk, input int e);
    exp_q.push_back({dc, lk, 18'(e)});
    wait (exp_q.size() == 0);
  endtask

  task automatic count(output int up, output int dn);
    up = 0; dn = 0;
    repeat (2) @(posedge ref_clk);
    for (int i = 0; i < 256; i++) begin
      @(negedge ref_clk);
      up += int'(pump_up); dn += int'(pump_dn);
    end
  endtask

  initial begin
    #(REF_PERIOD*20000);
    if (!done) begin
      done = 1; n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int up, dn, t0;
    repeat (3) @(negedge ref_clk);
    check("R1 pump_up", int'(pump_up), 0);
    check("R1 pump_dn", int'(pump_dn), 0);
    check("R1 locked", int'(locked), 0);
    check("R1 err_valid", int'(err_valid), 0);
    check("R1 err_out", int'(err_out), 0);
    rst_n = 1'b1;
    t0 = 0;
    while (!err_valid) begin @(negedge ref_clk); t0++; end
    check("R2 first valid latency", t0, 3*WIN);
    exp_q.push_back({1'b0, 1'b0, 18'd0});
    wait (exp_q.size() == 0);
    push(0, 0, 0);
    count(up, dn);
    check("R7 zero error up", up, 0);
    check("R7 zero error dn", dn, 0);
    push(0, 1, 0);                      // R9 third in-tolerance window
    offset = 18'sd5;
    push(0, 1, 5);                      // R9 at tolerance edge
    offset = 18'sd6;
    push(0, 0, 6);                      // R9 just outside
    offset = 18'sd40;
    push(0, 0, 40);
    count(up, dn);
    check("R5 up pulses for +40", up, 40);
    check("R6 no dn for +40", dn, 0);
    offset = -18'sd100;
    push(0, 0, -100);
    count(up, dn);
    check("R5 dn pulses for -100", dn, 100);
    check("R6 no up for -100", up, 0);
    offset = '0; osc_half = 2.0;
    push(1, 0, 0);
    push(1, 0, 0);
    push(0, 0, -600);
    count(up, dn);
    check("R5 clipped dn pulses", dn, 255);
    check("R6 no up for -600", up, 0);
    repeat (20) @(negedge ref_clk);
    offset = 18'sd600;
    repeat (10) @(negedge ref_clk);
    check("R4 err_out held mid-window", int'(err_out), -600);
    push(0, 0, 0);                      // R4 new offset applied at boundary
    enable = 1'b0; offset = 18'sd500;
    push(0, 0, -100);                   // R8 measurement continues
    count(up, dn);
    check("R8 no up while disabled", up, 0);
    check("R8 no dn while disabled", dn, 0);
    enable = 1'b1;
    push(0, 0, -100);
    count(up, dn);
    check("R8 dn resumes after enable", dn, 100);
    check("R6 pumps never together", overlap, 0);
    check("R3 outputs held between strobes", unstable, 0);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule